// File: doc/BRIEF.md
# Fully Associative LRU Byte Read Cache

This block sits between a processor load port and a slower memory. It keeps a small number of recently used memory blocks. Any block can occupy any line, because the address carries no index field. Each request carries a byte address. All line tags are compared against the address tag at the same time. On a match, the addressed byte comes back on the next cycle with the hit flag set.

When no line matches, the block raises a stall and closes its request port. It then sends the aligned block address to memory and waits for a single response that carries the whole block, however long memory takes. The block is written into an empty line if one exists. Otherwise it replaces the line that has gone unused the longest. The requested byte is returned one cycle after the memory response.

Two saturating counters report how many requests completed as hits and how many as misses.

Top module: `fa_lru_cache`

## Requirements
- R1: After reset every line is empty, both counters read 0, `req_ready_o` is 1, and `stall_o` and `rsp_valid_o` are 0.
- R2: The upper 4 address bits form the tag and bit 0 is the byte offset. An accepted request whose tag matches a valid line produces `rsp_valid_o`=1 and `rsp_hit_o`=1 on the following cycle.
- R3: The offset picks the byte within the block. Offset 0 returns `mem_rsp_data_i[7:0]` as it was stored at fill time, and offset 1 returns bits [15:8]. Bits [7:0] hold the byte at the even address.
- R4: On a miss, `stall_o` is 1 and `req_ready_o` is 0 from the cycle after acceptance until the memory response is taken. The requested byte then appears with `rsp_hit_o`=0 on the cycle after `mem_rsp_valid_i`.
- R5: `mem_req_addr_o` is the request address with bit 0 cleared. `mem_req_valid_o` and the address hold steady until `mem_req_ready_i` is seen, and exactly one request goes out per miss.
- R6: While any line is empty, a fill goes to the lowest-numbered empty line. No valid block is displaced.
- R7: With all lines valid, a fill replaces the least recently used line. Both hits and fills count as a use.
- R8: Each completed request adds one to the hit counter or the miss counter. Both counters are 16 bits wide and stop at 65535.
- R9: With memory byte i holding 100+10·i, the loads 1,5,1,4,0,12,5,12,5,12,5 from reset give 3 misses and 8 hits. They return 110,150,110,140,100,220,150,220,150,220,150.
- R10: No two valid lines ever hold the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | 5 | Byte address of the load |
| rsp_valid_o | output | 1 | Response byte valid (one-cycle pulse) |
| rsp_data_o | output | 8 | Returned byte |
| rsp_hit_o | output | 1 | Response came from a resident line |
| stall_o | output | 1 | Miss in progress |
| mem_req_valid_o | output | 1 | Block fetch request |
| mem_req_ready_i | input | 1 | Memory takes the fetch request |
| mem_req_addr_o | output | 5 | Aligned block address |
| mem_rsp_valid_i | input | 1 | Block data present |
| mem_rsp_data_i | input | 16 | Block data, even byte in low bits |
| hit_count_o | output | 16 | Saturating hit count |
| miss_count_o | output | 16 | Saturating miss count |

## Verification
A corrupted recency rank stays hidden until a fill happens with all lines valid. At that point the wrong block is evicted. The fault shows as an unexpected miss, or an unexpected hit, the next time either block is loaded, which can be many requests later. For that reason, random loads over a small address range are compared request by request against a timestamp model that keeps its own history. Separately, a bad stored tag or byte shows on the very next hit to that line, as a wrong `rsp_data_o` or a wrong `rsp_hit_o`.

// File: rtl/fa_cache_pkg.sv
package fa_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2
  } fill_state_e;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
  parameter int LINES = 4,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [LINES-1:0]            valid_i,
  input  logic [LINES-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]            tag_i,
  output logic [LINES-1:0]            match_o,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            hit_idx_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  assign hit_o = |match_o;

  always_comb begin
    hit_idx_o = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match_o[i]) hit_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/fa_lru_age.sv
module fa_lru_age #(
  parameter int LINES = 4,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic [LINES-1:0] valid_i,
  output logic [IDX_W-1:0] victim_o
);
  // rank 0 = most recent, LINES-1 = oldest; ranks stay a permutation
  logic [LINES-1:0][IDX_W-1:0] age_q;
  logic [IDX_W-1:0]            ref_age;
  logic [IDX_W-1:0]            oldest;
  logic                        free_found;

  assign ref_age = age_q[touch_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < LINES; i++) begin
        if (IDX_W'(i) == touch_idx_i)  age_q[i] <= '0;
        else if (age_q[i] < ref_age)   age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest = '0;
    for (int i = 0; i < LINES; i++) begin
      if (age_q[i] == IDX_W'(LINES - 1)) oldest = IDX_W'(i);
    end
  end

  always_comb begin
    free_found = 1'b0;
    victim_o   = oldest;
    for (int i = 0; i < LINES; i++) begin
      if (!valid_i[i] && !free_found) begin
        victim_o   = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fa_sat_ctr.sv
module fa_sat_ctr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      count_o <= '0;
    else if (inc_i && (count_o != '1)) count_o <= count_o + 1'b1;
  end
endmodule

// File: rtl/fa_lru_cache.sv
module fa_lru_cache
  import fa_cache_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int OFF_W  = 1,
  parameter int LINES  = 4,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16,
  localparam int TAG_W = ADDR_W - OFF_W,
  localparam int BLK_W = (1 << OFF_W) * BYTE_W,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [BYTE_W-1:0] rsp_data_o,
  output logic              rsp_hit_o,
  output logic              stall_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [BLK_W-1:0]  mem_rsp_data_i,
  output logic [CNT_W-1:0]  hit_count_o,
  output logic [CNT_W-1:0]  miss_count_o
);
  fill_state_e state_q, state_d;

  logic [LINES-1:0]            valid_q;
  logic [LINES-1:0][TAG_W-1:0] tag_q;
  logic [LINES-1:0][BLK_W-1:0] data_q;

  logic [ADDR_W-1:0] pend_addr_q;
  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_off, pend_off;
  logic [LINES-1:0]  line_match;
  logic              lookup_hit;
  logic [IDX_W-1:0]  hit_idx, victim_idx, touch_idx;
  logic              accept, hit_fire, miss_fire, fill_fire, touch;

  function automatic logic [BYTE_W-1:0] sel_byte(input logic [BLK_W-1:0] blk,
                                                  input logic [OFF_W-1:0] off);
    return blk[int'(off)*BYTE_W +: BYTE_W];
  endfunction

  assign req_tag  = req_addr_i[ADDR_W-1:OFF_W];
  assign req_off  = req_addr_i[OFF_W-1:0];
  assign pend_off = pend_addr_q[OFF_W-1:0];

  assign req_ready_o = (state_q == ST_IDLE);
  assign stall_o     = (state_q != ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign hit_fire    = accept && lookup_hit;
  assign miss_fire   = accept && !lookup_hit;
  assign fill_fire   = (state_q == ST_MWAIT) && mem_rsp_valid_i;
  assign touch       = hit_fire || fill_fire;
  assign touch_idx   = hit_fire ? hit_idx : victim_idx;

  assign mem_req_valid_o = (state_q == ST_MREQ);
  assign mem_req_addr_o  = {pend_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  fa_tag_match #(.LINES(LINES), .TAG_W(TAG_W)) u_match (
    .valid_i   (valid_q),
    .tags_i    (tag_q),
    .tag_i     (req_tag),
    .match_o   (line_match),
    .hit_o     (lookup_hit),
    .hit_idx_o (hit_idx)
  );

  fa_lru_age #(.LINES(LINES)) u_age (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch),
    .touch_idx_i (touch_idx),
    .valid_i     (valid_q),
    .victim_o    (victim_idx)
  );

  fa_sat_ctr #(.W(CNT_W)) u_hit_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (hit_fire),
    .count_o (hit_count_o)
  );

  fa_sat_ctr #(.W(CNT_W)) u_miss_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (fill_fire),
    .count_o (miss_count_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (miss_fire)       state_d = ST_MREQ;
      ST_MREQ:  if (mem_req_ready_i) state_d = ST_MWAIT;
      ST_MWAIT: if (mem_rsp_valid_i) state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pend_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (miss_fire) pend_addr_q <= req_addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      tag_q   <= '0;
      data_q  <= '0;
    end else if (fill_fire) begin
      for (int i = 0; i < LINES; i++) begin
        if (IDX_W'(i) == victim_idx) begin
          valid_q[i] <= 1'b1;
          tag_q[i]   <= pend_addr_q[ADDR_W-1:OFF_W];
          data_q[i]  <= mem_rsp_data_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= touch;
      if (hit_fire) begin
        rsp_hit_o  <= 1'b1;
        rsp_data_o <= sel_byte(data_q[hit_idx], req_off);
      end else if (fill_fire) begin
        rsp_hit_o  <= 1'b0;
        rsp_data_o <= sel_byte(mem_rsp_data_i, pend_off);
      end
    end
  end
endmodule

// File: rtl/fa_lru_cache_chk.sv
module fa_lru_cache_chk #(
  parameter int ADDR_W = 5,
  parameter int LINES  = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              stall_o,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic [CNT_W-1:0]  hit_count_o,
  input logic [CNT_W-1:0]  miss_count_o,
  input logic [LINES-1:0]  line_match
);
  AST_STALL_BLOCKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !req_ready_o); // R4

  AST_MEMREQ_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_req_addr_o[0] == 1'b0)); // R5

  AST_MEMREQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o))); // R5

  AST_MEMREQ_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && mem_req_ready_i) |=> !mem_req_valid_o); // R5

  AST_MISS_AFTER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> $past(stall_o)); // R4

  AST_HIT_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o && ($past(hit_count_o) != '1))
      |-> (hit_count_o == $past(hit_count_o) + 1'b1)); // R8

  AST_MISS_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o && ($past(miss_count_o) != '1))
      |-> (miss_count_o == $past(miss_count_o) + 1'b1)); // R8

  AST_HIT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_count_o == '1) |=> (hit_count_o == '1)); // R8

  AST_TAG_UNIQUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(line_match)); // R10
endmodule

bind fa_lru_cache fa_lru_cache_chk #(
  .ADDR_W (ADDR_W),
  .LINES  (LINES),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_ready_o     (req_ready_o),
  .stall_o         (stall_o),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_hit_o       (rsp_hit_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .hit_count_o     (hit_count_o),
  .miss_count_o    (miss_count_o),
  .line_match      (line_match)
);

// File: tb/sim_fa_lru_cache.sv
module sim_fa_lru_cache;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [4:0]  req_addr_i = '0;
  logic        rsp_valid_o;
  logic [7:0]  rsp_data_o;
  logic        rsp_hit_o;
  logic        stall_o;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [4:0]  mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [15:0] mem_rsp_data_i = '0;
  logic [15:0] hit_count_o;
  logic [15:0] miss_count_o;

  int n_chk  = 0;
  int n_fail = 0;

  // reference model: per-line last-use timestamps
  bit m_valid[NL];
  int m_tag[NL];
  int m_time[NL];
  int m_tick;
  int m_hits, m_misses;

  always #(CLK_PERIOD/2) clk = ~clk;

  fa_lru_cache u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_addr_i(req_addr_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o), .rsp_hit_o(rsp_hit_o),
    .stall_o(stall_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_data_i(mem_rsp_data_i),
    .hit_count_o(hit_count_o), .miss_count_o(miss_count_o)
  );

  function automatic logic [7:0] mem_byte(input int a);
    return 8'(100 + 10 * a);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic m_clear();
    for (int i = 0; i < NL; i++) begin
      m_valid[i] = 0; m_tag[i] = 0; m_time[i] = 0;
    end
    m_tick = 1; m_hits = 0; m_misses = 0;
  endtask

  task automatic m_access(input int a, output bit hit);
    int t;
    int v;
    t = a >> 1;
    hit = 0;
    for (int i = 0; i < NL; i++) begin
      if (m_valid[i] && m_tag[i] == t) begin
        hit = 1; m_time[i] = m_tick;
      end
    end
    if (!hit) begin
      v = -1;
      for (int i = 0; i < NL; i++) if (!m_valid[i] && v < 0) v = i;
      if (v < 0) begin
        v = 0;
        for (int i = 1; i < NL; i++) if (m_time[i] < m_time[v]) v = i;
      end
      m_valid[v] = 1; m_tag[v] = t; m_time[v] = m_tick;
    end
    m_tick++;
    if (hit) begin if (m_hits < 65535) m_hits++; end
    else     begin if (m_misses < 65535) m_misses++; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; req_valid_i = 1'b0; mem_req_ready_i = 1'b0; mem_rsp_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    m_clear();
    @(negedge clk);
  endtask

  task automatic do_load(input int a, input string lbl, input bit chk_cnt);
    bit exp_hit;
    int d;
    req_valid_i = 1'b1;
    req_addr_i  = 5'(a);
    m_access(a, exp_hit);
    @(negedge clk);
    req_valid_i = 1'b0;
    if (exp_hit) begin
      chk({lbl, " hit flag"}, int'(rsp_hit_o), 1);
      chk("R2 rsp_valid on hit", int'(rsp_valid_o), 1);
      chk("R3 hit byte", int'(rsp_data_o), int'(mem_byte(a)));
    end else begin
      chk({lbl, " miss flag rsp_valid"}, int'(rsp_valid_o), 0);
      chk("R4 stall after miss", int'(stall_o), 1);
      chk("R4 ready low in miss", int'(req_ready_o), 0);
      d = $urandom_range(0, 2);
      repeat (d) begin
        chk("R5 mem req held", int'(mem_req_valid_o), 1);
        chk("R5 mem addr held", int'(mem_req_addr_o), a & 30);
        @(negedge clk);
      end
      chk("R5 mem req", int'(mem_req_valid_o), 1);
      chk("R5 mem addr aligned", int'(mem_req_addr_o), a & 30);
      mem_req_ready_i = 1'b1;
      @(negedge clk);
      mem_req_ready_i = 1'b0;
      d = $urandom_range(0, 3);
      repeat (d) begin
        chk("R5 single mem req", int'(mem_req_valid_o), 0);
        chk("R4 ready low in wait", int'(req_ready_o), 0);
        @(negedge clk);
      end
      chk("R4 stall in wait", int'(stall_o), 1);
      mem_rsp_valid_i = 1'b1;
      mem_rsp_data_i  = {mem_byte(a | 1), mem_byte(a & 30)};
      @(negedge clk);
      mem_rsp_valid_i = 1'b0;
      chk("R4 rsp after fill", int'(rsp_valid_o), 1);
      chk("R4 miss hit flag", int'(rsp_hit_o), 0);
      chk("R3 miss byte", int'(rsp_data_o), int'(mem_byte(a)));
      chk("R4 stall released", int'(stall_o), 0);
    end
    if (chk_cnt) begin
      chk("R8 hit count", int'(hit_count_o), m_hits);
      chk("R8 miss count", int'(miss_count_o), m_misses);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seq[11];
    int a;
    void'($urandom(32'd20240611));
    seq = '{1, 5, 1, 4, 0, 12, 5, 12, 5, 12, 5};
    do_reset();

    // R1 reset state
    chk("R1 ready", int'(req_ready_o), 1);
    chk("R1 stall", int'(stall_o), 0);
    chk("R1 rsp_valid", int'(rsp_valid_o), 0);
    chk("R1 hit count", int'(hit_count_o), 0);
    chk("R1 miss count", int'(miss_count_o), 0);
    chk("R1 mem req", int'(mem_req_valid_o), 0);

    // R9 worked sequence
    foreach (seq[i]) do_load(seq[i], "R9", 1'b1);
    chk("R9 total misses", int'(miss_count_o), 3);
    chk("R9 total hits", int'(hit_count_o), 8);

    // R6 fill empty lines first, then R7 LRU victim
    do_reset();
    do_load(0, "R6", 1'b1); do_load(2, "R6", 1'b1);
    do_load(4, "R6", 1'b1); do_load(6, "R6", 1'b1);
    do_load(1, "R6", 1'b1); do_load(3, "R6", 1'b1);
    do_load(5, "R6", 1'b1); do_load(7, "R6", 1'b1);
    do_load(0, "R7", 1'b1);           // tag 1 now oldest
    do_load(8, "R7", 1'b1);           // evicts tag 1
    do_load(3, "R7", 1'b1);           // expected miss
    do_load(1, "R7", 1'b1);           // tag 0 still resident
    do_load(9, "R7", 1'b1);           // tag 4 recently filled

    // random mix
    do_reset();
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(0, 3) == 0) a = $urandom_range(0, 31);
      else                           a = $urandom_range(0, 11);
      do_load(a, "R7 random", 1'b1);
    end

    // R8 saturation with back-to-back hits
    do_reset();
    do_load(1, "R8", 1'b1);
    req_valid_i = 1'b1;
    req_addr_i  = 5'd0;
    repeat (65600) @(negedge clk);
    chk("R2 streamed hit", int'(rsp_hit_o), 1);
    chk("R3 streamed byte", int'(rsp_data_o), 100);
    req_valid_i = 1'b0;
    @(negedge clk);
    chk("R8 hit saturated", int'(hit_count_o), 65535);
    chk("R8 miss unchanged", int'(miss_count_o), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule